// File: doc/BRIEF.md
# Integer add, subtract and compare unit

This block is the arithmetic slice of a 64-bit integer execution pipe. A 7-bit function code selects one of several operations on two operands:

- add and subtract on the full quadword or on the low longword;
- scaled-index add and subtract, where operand A is first multiplied by 4 or 8;
- add and subtract variants that detect signed overflow;
- five scalar compares that return 0 or 1;
- a bytewise unsigned compare that returns an 8-bit lane mask.

Operand B comes either from the register input or from an 8-bit literal field. The literal is zero-extended.

Longword operations produce the low 32 bits of the arithmetic, sign-extended to the full width. An overflow-detecting operation still delivers the wrapped result alongside its fault flag, so the trap logic further down the pipe decides what to do with it. Function codes outside the supported set yield a zero result and raise an illegal-function flag.

All three outputs are registered, so every result appears one clock after its inputs are presented. A synchronous active-high reset clears them.

Top module: `ialu_arith`

## Requirements
- R1: While reset is asserted at a clock edge, the result, overflow flag and illegal flag are all zero after that edge.
- R2: Codes 0x00 (add) and 0x09 (subtract) operate on bits 31:0 of A and B; the 32-bit outcome is sign-extended from bit 31 to 64 bits, and the upper halves of the inputs have no effect.
- R3: Codes 0x20 (add) and 0x29 (subtract) give the 64-bit wrapped sum or difference A+B or A-B.
- R4: Scaled adds compute (A shifted left by 2)+B and (A shifted left by 3)+B. Longword forms are 0x02 (by 4) and 0x12 (by 8), with the R2 sign extension. Quadword forms are 0x22 (by 4) and 0x32 (by 8).
- R5: Scaled subtracts compute (A shifted left by 2)-B and (A shifted left by 3)-B. Longword forms are 0x0b (by 4) and 0x1b (by 8), with the R2 sign extension. Quadword forms are 0x2b (by 4) and 0x3b (by 8).
- R6: Overflow-detecting adds are 0x40 (longword) and 0x60 (quadword). The overflow flag is 1 exactly when A and B have equal sign bits and the result's sign bit differs from A's. The sign bit is bit 31 for longword and bit 63 for quadword. The wrapped result is still delivered.
- R7: Overflow-detecting subtracts are 0x49 (longword) and 0x69 (quadword). The overflow flag is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's. The wrapped result is still delivered.
- R8: Every code other than 0x40, 0x60, 0x49 and 0x69 leaves the overflow flag at 0, even when the arithmetic wraps.
- R9: Compares return 1 or 0 in bit 0, with bits 63:1 zero. The codes are: 0x2d A equal to B; 0x6d signed A less than or equal to B; 0x4d signed A less than B; 0x3d unsigned A less than or equal to B; 0x1d unsigned A less than B.
- R10: Code 0x0f compares byte i of A (bits 8i+7:8i) with byte i of B as unsigned values. Result bit i is 1 when A's byte is greater than or equal to B's. Bits 63:8 are zero.
- R11: When the literal select input is 1, operand B is the 8-bit literal zero-extended to 64 bits, and the B register input has no effect.
- R12: Any code not listed in R2 to R10 gives a zero result, an illegal flag of 1 and an overflow flag of 0. Listed codes give an illegal flag of 0.
- R13: Outputs are registered: a change on the inputs is visible on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 7 | Function code |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B register value |
| lit_i | input | LIT_W | Literal for operand B |
| lit_sel_i | input | 1 | 1 selects the zero-extended literal as operand B |
| result_o | output | DATA_W | Registered result |
| ovf_o | output | 1 | Registered signed-overflow fault flag |
| illegal_o | output | 1 | Registered illegal-function flag |

## Verification
The bench builds the unit with its default parameters: DATA_W of 64 and LIT_W of 8. With these values the longword sign bit sits at 31 and the quadword sign bit at 63, so both overflow positions and the longword sign extension can be reached. They also give eight byte lanes for the mask compare.

With an 8-bit literal, the literal path can be pitted against a bytewise compare, where the upper seven lanes of B are forced to zero. Stimulus places operands exactly at the signed boundaries, such as the largest positive value plus one and the most negative value minus one, so that overflow and wrap-around meet in the same operation.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  localparam int FUNC_W = 7;

  typedef enum logic [1:0] {
    K_ADD  = 2'd0,
    K_SUB  = 2'd1,
    K_CMP  = 2'd2,
    K_BYTE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_SLE = 3'd1,
    C_SLT = 3'd2,
    C_ULE = 3'd3,
    C_ULT = 3'd4
  } cmp_e;

  typedef struct packed {
    kind_e      kind;
    cmp_e       cmp;
    logic       long_op;
    logic [1:0] shift;
    logic       trap;
    logic       illegal;
  } ctl_t;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output ctl_t              ctl
);

  always_comb begin
    ctl         = '0;
    ctl.kind    = K_ADD;
    ctl.cmp     = C_EQ;
    unique case (func)
      7'h00: ctl.long_op = 1'b1;
      7'h20: ;
      7'h40: begin ctl.long_op = 1'b1; ctl.trap = 1'b1; end
      7'h60: ctl.trap = 1'b1;
      7'h02: begin ctl.long_op = 1'b1; ctl.shift = 2'd2; end
      7'h12: begin ctl.long_op = 1'b1; ctl.shift = 2'd3; end
      7'h22: ctl.shift = 2'd2;
      7'h32: ctl.shift = 2'd3;
      7'h09: begin ctl.kind = K_SUB; ctl.long_op = 1'b1; end
      7'h29: ctl.kind = K_SUB;
      7'h49: begin ctl.kind = K_SUB; ctl.long_op = 1'b1; ctl.trap = 1'b1; end
      7'h69: begin ctl.kind = K_SUB; ctl.trap = 1'b1; end
      7'h0b: begin ctl.kind = K_SUB; ctl.long_op = 1'b1; ctl.shift = 2'd2; end
      7'h1b: begin ctl.kind = K_SUB; ctl.long_op = 1'b1; ctl.shift = 2'd3; end
      7'h2b: begin ctl.kind = K_SUB; ctl.shift = 2'd2; end
      7'h3b: begin ctl.kind = K_SUB; ctl.shift = 2'd3; end
      7'h2d: begin ctl.kind = K_CMP; ctl.cmp = C_EQ;  end
      7'h6d: begin ctl.kind = K_CMP; ctl.cmp = C_SLE; end
      7'h4d: begin ctl.kind = K_CMP; ctl.cmp = C_SLT; end
      7'h3d: begin ctl.kind = K_CMP; ctl.cmp = C_ULE; end
      7'h1d: begin ctl.kind = K_CMP; ctl.cmp = C_ULT; end
      7'h0f: ctl.kind = K_BYTE;
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              long_op,
  input  logic [1:0]        shift,
  input  logic              trap,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  localparam int LONG_W = DATA_W / 2;

  logic [DATA_W-1:0] a_scaled;
  logic [DATA_W-1:0] raw;
  logic              sa, sb, sr;

  always_comb begin
    a_scaled = a << shift;
    raw      = sub ? (a_scaled - b) : (a_scaled + b);
    if (long_op) begin
      res = {{(DATA_W-LONG_W){raw[LONG_W-1]}}, raw[LONG_W-1:0]};
      sa  = a_scaled[LONG_W-1];
      sb  = b[LONG_W-1];
      sr  = raw[LONG_W-1];
    end else begin
      res = raw;
      sa  = a_scaled[DATA_W-1];
      sb  = b[DATA_W-1];
      sr  = raw[DATA_W-1];
    end
    ovf = trap & (sub ? (sa != sb) : (sa == sb)) & (sr != sa);
  end

endmodule

// File: rtl/ialu_cmp.sv
module ialu_cmp
  import ialu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cmp_e              cmp,
  output logic [DATA_W-1:0] res
);

  logic hit;
  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    unique case (cmp)
      C_EQ:    hit = eq;
      C_SLE:   hit = slt | eq;
      C_SLT:   hit = slt;
      C_ULE:   hit = ult | eq;
      C_ULT:   hit = ult;
      default: hit = 1'b0;
    endcase
    res = {{(DATA_W-1){1'b0}}, hit};
  end

endmodule

// File: rtl/ialu_bytecmp.sv
module ialu_bytecmp #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  logic [LANES-1:0] mask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W]);
  end

  assign res = {{(DATA_W-LANES){1'b0}}, mask};

endmodule

// File: rtl/ialu_arith.sv
module ialu_arith
  import ialu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FUNC_W-1:0]   func_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [LIT_W-1:0]    lit_i,
  input  logic                lit_sel_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                ovf_o,
  output logic                illegal_o
);

  localparam int LONG_W = DATA_W / 2;
  localparam int LANES  = DATA_W / 8;

  ctl_t              ctl;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] as_res, cmp_res, byte_res;
  logic              as_ovf;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ovf;
  logic [DATA_W-1:0] res_q;
  logic              ovf_q, ill_q;

  assign opb = lit_sel_i ? {{(DATA_W-LIT_W){1'b0}}, lit_i} : b_i;

  ialu_decode u_dec (.func(func_i), .ctl(ctl));

  ialu_addsub #(.DATA_W(DATA_W)) u_as (
    .a(a_i), .b(opb), .sub(ctl.kind == K_SUB), .long_op(ctl.long_op),
    .shift(ctl.shift), .trap(ctl.trap), .res(as_res), .ovf(as_ovf)
  );

  ialu_cmp #(.DATA_W(DATA_W)) u_cmp (.a(a_i), .b(opb), .cmp(ctl.cmp), .res(cmp_res));

  ialu_bytecmp #(.DATA_W(DATA_W)) u_byte (.a(a_i), .b(opb), .res(byte_res));

  always_comb begin
    nxt_ovf = 1'b0;
    unique case (ctl.kind)
      K_ADD, K_SUB: begin nxt_res = as_res; nxt_ovf = as_ovf; end
      K_CMP:        nxt_res = cmp_res;
      K_BYTE:       nxt_res = byte_res;
      default:      nxt_res = '0;
    endcase
    if (ctl.illegal) begin
      nxt_res = '0;
      nxt_ovf = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      res_q <= nxt_res;
      ovf_q <= nxt_ovf;
      ill_q <= ctl.illegal;
    end
  end

  assign result_o  = res_q;
  assign ovf_o     = ovf_q;
  assign illegal_o = ill_q;

  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    ill_q |-> (res_q == '0) && !ovf_q);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $past(ctl.trap));

  a_r9_cmp_bool: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.kind == K_CMP && !ctl.illegal) |-> (res_q[DATA_W-1:1] == '0));

  a_r10_mask_high_zero: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.kind == K_BYTE && !ctl.illegal) |-> (res_q[DATA_W-1:LANES] == '0));

  a_r2_long_sext: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.long_op && !ctl.illegal && ctl.kind != K_CMP && ctl.kind != K_BYTE)
      |-> (res_q[DATA_W-1:LONG_W-1] == '0 || res_q[DATA_W-1:LONG_W-1] == '1));

endmodule

// File: tb/sim_ialu_arith.sv
`timescale 1ns/1ps
module sim_ialu_arith;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  func = '0;
  logic [63:0] a_in = '0;
  logic [63:0] b_in = '0;
  logic [7:0]  lit_in = '0;
  logic        lsel = 1'b0;
  logic [63:0] result_o;
  logic        ovf_o, illegal_o;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    logic        ill;
    string       tag;
  } item_t;

  item_t       q[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_res = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ialu_arith u0 (
    .clk(clk), .rst(rst), .func_i(func), .a_i(a_in), .b_i(b_in),
    .lit_i(lit_in), .lit_sel_i(lsel),
    .result_o(result_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
  );

  function automatic item_t model(input logic [6:0] f, input logic [63:0] a,
                                  input logic [63:0] b);
    item_t e;
    logic arith, sub, lng, trp;
    int sh;
    logic [63:0] as_v, r;
    logic [31:0] l;
    e.res = '0; e.ovf = 1'b0; e.ill = 1'b0; e.tag = "";
    arith = 1'b1; sub = 1'b0; lng = 1'b0; trp = 1'b0; sh = 0;
    case (f)
      7'h00: lng = 1'b1;
      7'h20: ;
      7'h40: begin lng = 1'b1; trp = 1'b1; end
      7'h60: trp = 1'b1;
      7'h09: begin sub = 1'b1; lng = 1'b1; end
      7'h29: sub = 1'b1;
      7'h49: begin sub = 1'b1; lng = 1'b1; trp = 1'b1; end
      7'h69: begin sub = 1'b1; trp = 1'b1; end
      7'h02: begin lng = 1'b1; sh = 2; end
      7'h12: begin lng = 1'b1; sh = 3; end
      7'h22: sh = 2;
      7'h32: sh = 3;
      7'h0b: begin sub = 1'b1; lng = 1'b1; sh = 2; end
      7'h1b: begin sub = 1'b1; lng = 1'b1; sh = 3; end
      7'h2b: begin sub = 1'b1; sh = 2; end
      7'h3b: begin sub = 1'b1; sh = 3; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      as_v = a << sh;
      r = sub ? as_v - b : as_v + b;
      if (lng) begin
        l = r[31:0];
        e.res = {{32{l[31]}}, l};
        if (trp) e.ovf = (sub ? (as_v[31] != b[31]) : (as_v[31] == b[31])) && (l[31] != as_v[31]);
      end else begin
        e.res = r;
        if (trp) e.ovf = (sub ? (a[63] != b[63]) : (a[63] == b[63])) && (r[63] != a[63]);
      end
    end else begin
      case (f)
        7'h2d: e.res = {63'b0, a == b};
        7'h6d: e.res = {63'b0, $signed(a) <= $signed(b)};
        7'h4d: e.res = {63'b0, $signed(a) < $signed(b)};
        7'h3d: e.res = {63'b0, a <= b};
        7'h1d: e.res = {63'b0, a < b};
        7'h0f: for (int i = 0; i < 8; i++) e.res[i] = (a[8*i +: 8] >= b[8*i +: 8]);
        default: e.ill = 1'b1;
      endcase
    end
    return e;
  endfunction

  task automatic send(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                      input logic [7:0] lit, input logic ls, input string tag);
    item_t it;
    @(negedge clk);
    func = f; a_in = a; b_in = b; lit_in = lit; lsel = ls;
    it = model(f, a, ls ? {56'b0, lit} : b);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (!rst && q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (result_o !== it.res || ovf_o !== it.ovf || illegal_o !== it.ill) begin
        errors++;
        $display("FAIL %s: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
                 it.tag, result_o, ovf_o, illegal_o, it.res, it.ovf, it.ill);
      end
      last_res = result_o;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with live inputs
    func = 7'h20; a_in = 64'h1234; b_in = 64'h1;
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== '0 || ovf_o !== 1'b0 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got res=%h ovf=%b ill=%b, expected all zero", result_o, ovf_o, illegal_o);
    end
    rst = 1'b0;

    // R2: longword add/sub with sign extension
    send(7'h00, 64'h0000_0000_7fff_ffff, 64'h1, 8'h0, 1'b0, "R2");
    send(7'h09, 64'h0, 64'h1, 8'h0, 1'b0, "R2");
    send(7'h00, 64'hdead_beef_0000_0005, 64'h7777_0000_0000_0003, 8'h0, 1'b0, "R2");
    // R3: quadword add/sub
    send(7'h20, 64'hffff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R3");
    send(7'h29, 64'h5, 64'h7, 8'h0, 1'b0, "R3");
    // R4: scaled adds
    send(7'h22, 64'h3, 64'h5, 8'h0, 1'b0, "R4");
    send(7'h32, 64'h1000_0000_0000_0001, 64'h2, 8'h0, 1'b0, "R4");
    send(7'h02, 64'h2000_0000, 64'h0, 8'h0, 1'b0, "R4");
    send(7'h12, 64'h1000_0000, 64'h0, 8'h0, 1'b0, "R4");
    // R5: scaled subtracts
    send(7'h2b, 64'h3, 64'h20, 8'h0, 1'b0, "R5");
    send(7'h3b, 64'h10, 64'h1, 8'h0, 1'b0, "R5");
    send(7'h0b, 64'h1, 64'h5, 8'h0, 1'b0, "R5");
    send(7'h1b, 64'hffff_0000_0fff_ffff, 64'h1, 8'h0, 1'b0, "R5");
    // R6: overflow-detecting adds
    send(7'h60, 64'h7fff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R6");
    send(7'h40, 64'h7fff_ffff, 64'h1, 8'h0, 1'b0, "R6");
    send(7'h60, 64'hffff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R6");
    send(7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h0, 1'b0, "R6");
    // R7: overflow-detecting subtracts
    send(7'h69, 64'h8000_0000_0000_0000, 64'h1, 8'h0, 1'b0, "R7");
    send(7'h49, 64'h8000_0000, 64'h1, 8'h0, 1'b0, "R7");
    send(7'h69, 64'h5, 64'h3, 8'h0, 1'b0, "R7");
    send(7'h49, 64'h8000_0000, 64'h8000_0001, 8'h0, 1'b0, "R7");
    // R8: wrapping codes without detection
    send(7'h20, 64'h7fff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R8");
    send(7'h09, 64'h8000_0000, 64'h1, 8'h0, 1'b0, "R8");
    // R9: compares
    send(7'h2d, 64'h55, 64'h55, 8'h0, 1'b0, "R9");
    send(7'h2d, 64'h55, 64'h56, 8'h0, 1'b0, "R9");
    send(7'h4d, 64'hffff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R9");
    send(7'h1d, 64'hffff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R9");
    send(7'h6d, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h0, 1'b0, "R9");
    send(7'h3d, 64'h2, 64'h1, 8'h0, 1'b0, "R9");
    // R10: bytewise compare
    send(7'h0f, 64'h0011_2233_4455_6677, 64'h0012_2232_ff00_6678, 8'h0, 1'b0, "R10");
    send(7'h0f, 64'hcafe_f00d_1234_5678, 64'hcafe_f00d_1234_5678, 8'h0, 1'b0, "R10");
    // R11: literal replaces B
    send(7'h20, 64'ha, 64'hffff_0000_ffff_0000, 8'hff, 1'b1, "R11");
    send(7'h0f, 64'h0, 64'hffff_ffff_ffff_ffff, 8'h01, 1'b1, "R11");
    // R12: illegal codes
    send(7'h01, 64'h1234, 64'h1, 8'h0, 1'b0, "R12");
    send(7'h7f, 64'h7fff_ffff_ffff_ffff, 64'h1, 8'h0, 1'b0, "R12");
    send(7'h61, 64'h5, 64'h5, 8'h0, 1'b0, "R12");
    drain();

    // R13: new inputs do not reach the outputs before the next edge
    send(7'h20, 64'h100, 64'h23, 8'h0, 1'b0, "R13");
    #1;
    checks++;
    if (result_o !== last_res) begin
      errors++;
      $display("FAIL R13: got res=%h before edge, expected %h", result_o, last_res);
    end
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule